// File: doc/BRIEF.md
# Multi-Slot Frame-Synchronised Serial Transmitter

This block turns frames of four 24-bit channel words into a single serial data line. It also generates the matching bit clock and a frame-sync strobe. A producer offers a whole frame, meaning all four channel words at once, through a valid/ready handshake. The frame waits in a one-entry staging register. All four words move into the shift path together, at the bit period that opens the frame. A receiver that samples on the rising edge of the generated clock can always find channel 0, because the strobe is raised only ahead of channel 0's first bit.

The bit clock is the system clock divided by `2*HALF_DIV`, and `FRAME_BITS` sets the number of bit periods in one frame. A frame that is accepted early enough follows the previous one with no gap: its strobe sits in the last bit period of the frame still being sent. When no frame is waiting, the transmitter finishes the frame in flight and then idles. While idle, the strobe stays low and the data line stays high.

Top module: `tdm_fsync_tx`

## Requirements
- R1: After reset `in_ready` is 1. A frame is taken on a clock where `in_valid` and `in_ready` are both 1, and `in_ready` then stays 0 until the bit period that carries that frame's first data bit begins.
- R2: `ser_clk` is 0 after reset. It toggles every `HALF_DIV` system clocks, so the bit period is `2*HALF_DIV` clocks with equal high and low time.
- R3: `ser_data` and `ser_fs` change only on the system clock edge where `ser_clk` goes from 1 to 0.
- R4: `ser_fs` is 1 for exactly one bit period, namely the bit period just before the first bit of slot 0.
- R5: `ser_fs` is never 1 unless a frame has been accepted and not yet started. No strobe appears before the first transfer or after the last one.
- R6: Slot k is taken from `in_data[24k+23:24k]`. Slots go out in the order 0, 1, 2, 3, each most significant bit first, in 96 back-to-back bit periods.
- R7: `ser_data` is 1 in every bit period that carries no slot bit. This covers idle time, the lead-in strobe period from idle, and the `FRAME_BITS-96` slack periods at the end of each frame.
- R8: If the next frame is accepted before the last bit period of the current frame begins, the next frame starts straight after it. Its strobe falls in that last bit period, so strobes are exactly `FRAME_BITS` bit periods apart.
- R9: If no frame is waiting when the last bit period begins, the current frame completes and the line goes idle. A later frame then starts with a strobe period of its own, so the spacing is larger than `FRAME_BITS` bit periods.
- R10: Reset gives `ser_clk`=0, `ser_data`=1, `ser_fs`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame is offered on `in_data` |
| in_ready | output | 1 | The staging register is free |
| in_data | input | SLOTS*WORD_W | Frame; slot k at bits [k*WORD_W +: WORD_W] |
| ser_clk | output | 1 | Generated bit clock |
| ser_data | output | 1 | Serial data, changes on the falling `ser_clk` edge |
| ser_fs | output | 1 | One-bit frame-sync strobe ahead of slot 0 |

## Verification
The hardest case to reach from the ports is a frame that arrives right around the last-bit decision point. The arrival has to land either just before or just after the bit period in which the transmitter must choose between raising the strobe again and going idle. The stimulus times the handshake relative to the rising edge of `in_ready`, which marks the first data bit of the frame in flight. Offering the next frame straight away produces gapless frames. Waiting 398 clocks, which falls just after the last bit period has begun, forces the stop-and-restart path. The spacing between strobes is then measured in both cases, and every clock is compared against a behavioural bit-queue model.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tdm_bitclk_gen.sv
module tdm_bitclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bclk,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == TOP) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // high on the edge that takes bclk from 1 to 0
  assign fall_tick = (cnt == TOP) && bclk;
endmodule

// File: rtl/tdm_frame_stage.sv
module tdm_frame_stage #(
  parameter int SLOTS  = 4,
  parameter int WORD_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [SLOTS*WORD_W-1:0] in_data,
  input  logic                    take,
  output logic                    in_ready,
  output logic                    full,
  output logic [SLOTS*WORD_W-1:0] stage_frame
);
  localparam int FW = SLOTS * WORD_W;

  logic [FW-1:0] ordered;
  logic          accept;
  logic          full_nxt;

  // slot 0 goes to the top so the shifter emits it first
  for (genvar s = 0; s < SLOTS; s++) begin : g_order
    assign ordered[FW-1-s*WORD_W -: WORD_W] = in_data[s*WORD_W +: WORD_W];
  end

  assign accept = in_valid && in_ready;

  always_comb begin
    full_nxt = full;
    if (take)        full_nxt = 1'b0;
    else if (accept) full_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      in_ready <= 1'b1;
    end else begin
      full     <= full_nxt;
      in_ready <= ~full_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) stage_frame <= ordered;
  end
endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
  import tdm_tx_pkg::*;
#(
  parameter int FW         = 96,
  parameter int FRAME_BITS = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_tick,
  input  logic          stage_full,
  input  logic [FW-1:0] stage_frame,
  output logic          take,
  output logic          ser_data,
  output logic          ser_fs
);
  localparam int POS_W = $clog2(FRAME_BITS + 1);
  localparam logic [POS_W-1:0] DATA_END = POS_W'(FW);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] END_POS  = POS_W'(FRAME_BITS);

  seq_state_t       state;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_nx;
  logic [FW-1:0]    shreg;

  assign pos_nx = pos + 1'b1;
  assign take   = fall_tick && (state == SEQ_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      pos      <= '0;
      shreg    <= '0;
      ser_data <= 1'b1;
      ser_fs   <= 1'b0;
    end else if (fall_tick) begin
      case (state)
        SEQ_ARMED: begin
          shreg    <= stage_frame << 1;
          ser_data <= stage_frame[FW-1];
          ser_fs   <= 1'b0;
          pos      <= '0;
          state    <= SEQ_RUN;
        end
        SEQ_RUN: begin
          pos <= pos_nx;
          if (pos_nx < DATA_END) begin
            ser_data <= shreg[FW-1];
            shreg    <= shreg << 1;
          end else begin
            ser_data <= 1'b1;
          end
          if (stage_full && (pos_nx >= LAST_POS)) begin
            ser_fs <= 1'b1;
            state  <= SEQ_ARMED;
          end else begin
            ser_fs <= 1'b0;
            if (pos_nx == END_POS) state <= SEQ_IDLE;
          end
        end
        default: begin
          ser_data <= 1'b1;
          if (stage_full) begin
            ser_fs <= 1'b1;
            state  <= SEQ_ARMED;
          end else begin
            ser_fs <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tdm_fsync_tx.sv
module tdm_fsync_tx #(
  parameter int SLOTS      = 4,
  parameter int WORD_W     = 24,
  parameter int FRAME_BITS = 96,
  parameter int HALF_DIV   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SLOTS*WORD_W-1:0] in_data,
  output logic                    ser_clk,
  output logic                    ser_data,
  output logic                    ser_fs
);
  localparam int FW = SLOTS * WORD_W;

  logic          fall_tick;
  logic          take;
  logic          stage_full;
  logic [FW-1:0] stage_frame;

  tdm_bitclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk       (clk),
    .rst       (rst),
    .bclk      (ser_clk),
    .fall_tick (fall_tick)
  );

  tdm_frame_stage #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_stage (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .take        (take),
    .in_ready    (in_ready),
    .full        (stage_full),
    .stage_frame (stage_frame)
  );

  tdm_slot_sequencer #(.FW(FW), .FRAME_BITS(FRAME_BITS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .fall_tick   (fall_tick),
    .stage_full  (stage_full),
    .stage_frame (stage_frame),
    .take        (take),
    .ser_data    (ser_data),
    .ser_fs      (ser_fs)
  );
endmodule

// File: rtl/tdm_fsync_tx_checker.sv
module tdm_fsync_tx_checker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_fs
);
  localparam int CW = $clog2(2 * HALF_DIV + 2);

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] same_cnt;
  logic          clk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      same_cnt <= '0;
      clk_d    <= 1'b0;
    end else begin
      hi_cnt   <= ser_fs ? hi_cnt + 1'b1 : '0;
      same_cnt <= (ser_clk != clk_d) ? CW'(1) : same_cnt + 1'b1;
      clk_d    <= ser_clk;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R1
  AST_CLK_HALF: assert property (@(posedge clk) disable iff (rst)
    (ser_clk != clk_d) |-> (same_cnt == CW'(HALF_DIV))); // R2
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> $fell(ser_clk)); // R3
  AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_fs) |-> $fell(ser_clk)); // R3
  AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_fs) |-> (hi_cnt == CW'(2 * HALF_DIV))); // R4
  AST_FS_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_fs) |-> !in_ready); // R5
endmodule

bind tdm_fsync_tx tdm_fsync_tx_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_fs   (ser_fs)
);

// File: tb/tb_tdm_fsync_tx.sv
`timescale 1ns/1ps
module tb_tdm_fsync_tx;
  localparam int SLOTS = 4;
  localparam int W     = 24;
  localparam int FB    = 100;
  localparam int H     = 2;
  localparam int FW    = SLOTS * W;
  localparam int FRAME_CYC = FB * 2 * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [FW-1:0] in_data = '0;
  logic ser_clk, ser_data, ser_fs;

  always #2 clk = ~clk;

  tdm_fsync_tx #(.SLOTS(SLOTS), .WORD_W(W), .FRAME_BITS(FB), .HALF_DIV(H)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ser_clk(ser_clk), .ser_data(ser_data), .ser_fs(ser_fs)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int n = 0;
  logic exp_clk = 1'b0, exp_data = 1'b1, exp_fs = 1'b0, exp_ready = 1'b1;
  int exp_kind = 0;                 // 0 idle, 1 lead, 2 data, 3 slack
  logic [FW-1:0] fq[$];
  int bq[$];                        // entry = data | kind<<1
  bit pend_pop = 1'b0;

  task automatic append_frame(input logic [FW-1:0] f);
    for (int s = 0; s < SLOTS; s++)
      for (int b = W - 1; b >= 0; b--)
        bq.push_back(int'(f[s*W + b]) | (2 << 1));
    for (int k = FW; k < FB; k++) bq.push_back(1 | (3 << 1));
  endtask

  task automatic bit_tick();
    int e;
    if (pend_pop) begin
      void'(fq.pop_front());
      pend_pop = 1'b0;
    end
    if (bq.size() == 0) begin
      exp_data = 1'b1;
      if (fq.size() > 0) begin
        exp_fs = 1'b1; exp_kind = 1;
        append_frame(fq[0]); pend_pop = 1'b1;
      end else begin
        exp_fs = 1'b0; exp_kind = 0;
      end
    end else begin
      e = bq.pop_front();
      exp_data = e[0];
      exp_kind = e >> 1;
      exp_fs = 1'b0;
      if (bq.size() == 0 && fq.size() > 0) begin
        exp_fs = 1'b1;
        append_frame(fq[0]); pend_pop = 1'b1;
      end
    end
  endtask

  always @(posedge clk) begin
    bit acc;
    if (rst) begin
      n = 0; exp_clk = 1'b0; exp_data = 1'b1; exp_fs = 1'b0; exp_kind = 0;
      fq.delete(); bq.delete(); pend_pop = 1'b0;
    end else begin
      acc = in_valid && (fq.size() == 0);
      n++;
      exp_clk = ((n / H) % 2) == 1;
      if (n % (2 * H) == 0) bit_tick();
      if (acc) fq.push_back(in_data);
    end
    exp_ready = (fq.size() == 0);
  end

  // ---------------- per-clock comparison and edge monitor ----------------
  logic prev_clk = 1'b0, prev_data = 1'b1, prev_fs = 1'b0;
  int rises[$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(ser_clk == exp_clk, "R2 bit clock", 32'(ser_clk), 32'(exp_clk));
      chk(in_ready == exp_ready, "R1 ready", 32'(in_ready), 32'(exp_ready));
      chk(ser_fs == exp_fs, (exp_kind == 0) ? "R5 strobe while idle" : "R4 strobe",
          32'(ser_fs), 32'(exp_fs));
      chk(ser_data == exp_data, (exp_kind == 2) ? "R6 slot bit" : "R7 default level",
          32'(ser_data), 32'(exp_data));
      if (ser_data != prev_data || ser_fs != prev_fs)
        chk(prev_clk && !ser_clk, "R3 change off falling edge", 32'(ser_clk), 32'(0));
      if (ser_fs && !prev_fs) rises.push_back(n);
    end
    prev_clk = ser_clk; prev_data = ser_data; prev_fs = ser_fs;
  end

  // ---------------- stimulus ----------------
  function automatic logic [FW-1:0] mk(input logic [W-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic send(input logic [FW-1:0] f);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data  = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_window(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(ser_fs == 1'b0, "R5 no strobe after stop", 32'(ser_fs), 32'(0));
      chk(ser_data == 1'b1, "R9 idle after last frame", 32'(ser_data), 32'(1));
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset values while still in reset
    chk(ser_clk == 1'b0, "R10 ser_clk", 32'(ser_clk), 32'(0));
    chk(ser_data == 1'b1, "R10 ser_data", 32'(ser_data), 32'(1));
    chk(ser_fs == 1'b0, "R10 ser_fs", 32'(ser_fs), 32'(0));
    chk(in_ready == 1'b1, "R10 in_ready", 32'(in_ready), 32'(1));
    rst = 1'b0;

    // idle before any transfer: no strobe (R5)
    idle_window(60);

    // back-to-back frames (R8, R6)
    rises.delete();
    send(mk(24'h111111, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF));
    send(mk(24'hA5C3F0, 24'h000000, 24'h800001, 24'h5A5A5A));
    send(mk(24'h123456, 24'h789ABC, 24'hDEF012, 24'hFFFFFF));
    repeat (4 * FRAME_CYC) @(negedge clk);
    chk(rises.size() == 3, "R8 strobe count", 32'(rises.size()), 32'(3));
    if (rises.size() == 3) begin
      chk(rises[1] - rises[0] == FRAME_CYC, "R8 gapless spacing 1",
          32'(rises[1] - rises[0]), 32'(FRAME_CYC));
      chk(rises[2] - rises[1] == FRAME_CYC, "R8 gapless spacing 2",
          32'(rises[2] - rises[1]), 32'(FRAME_CYC));
    end
    idle_window(2 * FRAME_CYC);

    // late next frame: stop then restart (R9)
    rises.delete();
    send(mk(24'h000001, 24'h800000, 24'h0F0F0F, 24'hF0F0F0));
    while (!in_ready) @(negedge clk);
    repeat (398) @(negedge clk);
    send(mk(24'hC0FFEE, 24'h00BEEF, 24'hFFFFFE, 24'h7FFFFF));
    repeat (3 * FRAME_CYC) @(negedge clk);
    chk(rises.size() == 2, "R9 strobe count", 32'(rises.size()), 32'(2));
    if (rises.size() == 2)
      chk(rises[1] - rises[0] > FRAME_CYC, "R9 restart gap",
          32'(rises[1] - rises[0]), 32'(FRAME_CYC + 1));
    idle_window(FRAME_CYC);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule